// File: doc/BRIEF.md
# Round-Robin Converter Channel Scanner

This block is the host side of a full-duplex serial link to an 8-bit successive-approximation converter. It scans converter channels 0 to 8 without end. Each frame is eight serial clocks long. During a frame the block shifts out a 4-bit channel address, followed by four zero bits. At the same time it shifts in the 8-bit result of the conversion that the previous frame requested. Each returned byte therefore belongs to the channel that was addressed one frame earlier. The block tracks that channel and writes the byte into a per-channel result register. When it stores a byte, it pulses a one-cycle strobe together with the channel index and the data.

After a frame the converter needs time to convert. The block drives the conversion clock itself. In counted mode (`wait_mode` = 0) it waits a fixed number of conversion-clock rising edges. In handshake mode (`wait_mode` = 1) it waits for a low-to-high transition on the end-of-conversion input. The serial clock comes from a programmable divider of the system clock. Chip select falls a set number of conversion-clock edges before the first serial edge.

The controller has four states:
- IDLE is the state after reset. It moves to SETUP on the next cycle and loads address 0.
- SETUP holds chip select low and counts conversion-clock rises. After `CS_SETUP` of them it moves to SHIFT.
- SHIFT runs the eight serial clocks. On the eighth falling edge it stores the byte and moves to WAIT.
- WAIT holds chip select high. When the wait condition is met it moves back to SETUP with the next address.

Top module: `adc_scan_host`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `sclk` is 0, `res_valid` is 0, and every result register reads 0.
- R2: After reset, the addresses sent are 0,1,...,8,0,1,... in that order. Each address occupies the first four bits of the frame, MSB first, and the last four bits sent are 0.
- R3: `sclk` idles low and runs exactly 8 cycles per frame, with a period of 2*`SCLK_HALF` system clocks. `mosi` changes only on falling `sclk` edges or while `sclk` is idle.
- R4: `miso` is sampled on each rising `sclk` edge and assembled MSB first into the received byte.
- R5: The byte received in frame k is stored for the channel addressed in frame k-1. The byte from the first frame after reset is discarded: there is no strobe and no register write.
- R6: In counted mode, `cs_n` falls on exactly the `CONV_CLKS`-th (32nd) rising edge of `adc_clk` after the frame ends.
- R7: In handshake mode, `cs_n` stays high after a frame until `eoc` has made a low-to-high transition. After that transition the next frame begins.
- R8: At least `CS_SETUP` (3) rising edges of `adc_clk` occur between the fall of `cs_n` and the first rising `sclk` edge.
- R9: `res_valid` is a one-cycle pulse and never lasts two cycles. It comes with `res_chan` below 9 and with the stored byte on `res_data`.
- R10: `rd_data` returns the result register selected by `rd_chan`. It already shows the new byte in the cycle in which `res_valid` is high. An index of 9 or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_mode | input | 1 | 0: counted conversion wait, 1: wait for `eoc` rising edge |
| eoc | input | 1 | End-of-conversion from the converter (asynchronous) |
| miso | input | 1 | Serial result data from the converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial address data to the converter |
| adc_clk | output | 1 | Free-running conversion clock |
| res_valid | output | 1 | One-cycle strobe when a result is stored |
| res_chan | output | 4 | Channel of the stored result |
| res_data | output | 8 | Stored result byte |
| rd_chan | input | 4 | Result register read select |
| rd_data | output | 8 | Result register contents |

## Verification
A register write and a readback of the same register can fall in the same cycle. The bench holds `rd_chan` on channel 4 while scanning is under way. Whenever `res_valid` pulses for that channel, it compares `rd_data` in the strobe cycle against `res_data`, which must already hold the new byte. The end of conversion can also be signalled while counted mode is active. The bench toggles `eoc` after every frame in that mode and still requires the wait to be exactly 32 conversion-clock rises.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_WAIT  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic adc_clk,
    output logic rise_tick
);
    localparam int CW = $clog2(HALF) + 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF - 1));
    assign rise_tick = wrap && !adc_clk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            adc_clk <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            adc_clk <= ~adc_clk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r6_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> adc_clk);
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int SCLK_HALF = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int DW    = $clog2(SCLK_HALF) + 1;
    localparam int BW    = $clog2(DATA_W);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DW-1:0]     div_cnt;
    logic [BW-1:0]     bit_cnt;
    logic [DATA_W-1:0] tx_sr;
    logic              busy;
    logic              half_end;

    assign half_end = busy && (div_cnt == DW'(SCLK_HALF - 1));
    assign done     = half_end && sclk && (bit_cnt == BW'(DATA_W - 1));
    assign mosi     = tx_sr[DATA_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_byte <= '0;
        end else begin
            if (load) begin
                tx_sr <= {addr, {PAD_W{1'b0}}};
            end
            if (start) begin
                busy    <= 1'b1;
                sclk    <= 1'b0;
                div_cnt <= '0;
                bit_cnt <= '0;
            end else if (half_end) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[DATA_W-2:0], miso};
                end else begin
                    sclk    <= 1'b0;
                    tx_sr   <= {tx_sr[DATA_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BW'(DATA_W - 1)) begin
                        busy <= 1'b0;
                    end
                end
            end else if (busy) begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R3: data to the converter is steady across every rising serial edge
    a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(sclk)) |-> $stable(mosi));
    // R3: the serial clock rests low between frames
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 9,
    parameter int CH_W   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

    a_r9_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ch < CH_W'(NUM_CH)));
endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH    = 9,
    parameter int CH_W      = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int SCLK_HALF = 2,
    parameter int ADC_HALF  = 4,
    parameter int CONV_CLKS = 32,
    parameter int CS_SETUP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_mode,
    input  logic              eoc,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              adc_clk,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SW = $clog2(CS_SETUP) + 1;
    localparam int WW = $clog2(CONV_CLKS) + 1;

    scan_state_t       state, state_nx;
    logic [SW-1:0]     setup_cnt;
    logic [WW-1:0]     wait_cnt;
    logic [CH_W-1:0]   send_ch, prev_ch;
    logic              have_prev, mode_q;
    logic              eoc_m, eoc_s, eoc_d, eoc_rise;
    logic              adc_rise, frame_done;
    logic              load_addr, start_shift, store;
    logic [DATA_W-1:0] rx_byte;

    adc_conv_clk #(.HALF(ADC_HALF)) u_cclk (
        .clk(clk), .rst_n(rst_n), .adc_clk(adc_clk), .rise_tick(adc_rise)
    );

    adc_frame_shifter #(.SCLK_HALF(SCLK_HALF), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_addr), .addr(ADDR_W'(send_ch)),
        .start(start_shift), .miso(miso), .sclk(sclk), .mosi(mosi),
        .done(frame_done), .rx_byte(rx_byte)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(store), .wr_ch(prev_ch), .wr_data(rx_byte),
        .rd_ch(rd_chan), .rd_data(rd_data)
    );

    assign eoc_rise = eoc_s && !eoc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_SETUP;
            ST_SETUP: if (adc_rise && setup_cnt == SW'(CS_SETUP - 1)) state_nx = ST_SHIFT;
            ST_SHIFT: if (frame_done) state_nx = ST_WAIT;
            ST_WAIT:  if (mode_q ? eoc_rise
                                 : (adc_rise && wait_cnt == WW'(CONV_CLKS - 1)))
                          state_nx = ST_SETUP;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_addr   = (state_nx == ST_SETUP) && (state != ST_SETUP);
        start_shift = (state == ST_SETUP) && (state_nx == ST_SHIFT);
        store       = (state == ST_SHIFT) && frame_done && have_prev;
        cs_n        = !((state == ST_SETUP) || (state == ST_SHIFT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_cnt <= '0;
            wait_cnt  <= '0;
            send_ch   <= '0;
            prev_ch   <= '0;
            have_prev <= 1'b0;
            mode_q    <= 1'b0;
            eoc_m     <= 1'b0;
            eoc_s     <= 1'b0;
            eoc_d     <= 1'b0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
        end else begin
            eoc_m <= eoc;
            eoc_s <= eoc_m;
            eoc_d <= eoc_s;
            if (state != ST_SETUP)  setup_cnt <= '0;
            else if (adc_rise)      setup_cnt <= setup_cnt + 1'b1;
            if (state != ST_WAIT)   wait_cnt  <= '0;
            else if (adc_rise)      wait_cnt  <= wait_cnt + 1'b1;
            if (state == ST_SHIFT && frame_done) begin
                prev_ch   <= send_ch;
                have_prev <= 1'b1;
                mode_q    <= wait_mode;
                send_ch   <= (send_ch == CH_W'(NUM_CH - 1)) ? '0 : send_ch + 1'b1;
            end
            res_valid <= store;
            if (store) begin
                res_chan <= prev_ch;
                res_data <= rx_byte;
            end
        end
    end

    // R9: the store strobe never lasts two cycles
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9: the reported channel lies inside the scan set
    a_r9_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan < CH_W'(NUM_CH)));
    // R7: with no end-of-conversion edge pending, select stays released
    a_r7_eoc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mode_q && !eoc_s) |=> cs_n);
    // R6: a counted wait ends only on its final conversion-clock rise
    a_r6_count_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && $past(state) == ST_WAIT && !$past(mode_q))
            |-> ($past(wait_cnt) == WW'(CONV_CLKS - 1)));
    // R8: the serial clock never starts before the setup rises are counted
    a_r8_setup_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && !adc_rise) |=> (state != ST_SHIFT));
endmodule

// File: tb/tb_adc_scan_host.sv
module tb_adc_scan_host;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wait_mode = 1'b0;
    logic       eoc = 1'b1;
    logic       miso;
    logic       sclk, cs_n, mosi, adc_clk, res_valid;
    logic [3:0] res_chan, rd_chan = 4'd0;
    logic [7:0] res_data, rd_data;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_scan_host dut (
        .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .eoc(eoc), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .adc_clk(adc_clk),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .rd_chan(rd_chan), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] conv_val(input logic [3:0] a, input int k);
        conv_val = {a, 4'h0} ^ 8'(8'h3C + k * 7);
    endfunction

    // ---------------- converter model ----------------
    logic [7:0] s_out = 8'hEE;
    logic [7:0] s_in = 8'h00;
    int         s_idx = 0;
    int         s_frames = 0;
    logic [3:0] s_hist [0:63];
    logic [3:0] s_pad  [0:63];
    logic [7:0] s_val  [0:63];
    event       fr_done;

    assign miso = cs_n ? 1'b0 : s_out[7 - s_idx];

    always @(posedge sclk) s_in = {s_in[6:0], mosi};

    always @(negedge sclk) begin
        if (s_idx == 7) begin
            if (s_frames < 64) begin
                s_hist[s_frames] = s_in[7:4];
                s_pad[s_frames]  = s_in[3:0];
                s_val[s_frames]  = conv_val(s_in[7:4], s_frames);
                s_out            = s_val[s_frames];
            end
            s_frames++;
            s_idx = 0;
            -> fr_done;
        end else begin
            s_idx++;
        end
    end

    always begin
        @(fr_done);
        eoc = 1'b0;
        repeat (400) @(posedge clk);
        eoc = 1'b1;
    end

    // ---------------- strobe monitor ----------------
    logic [3:0] v_ch  [0:63];
    logic [7:0] v_dat [0:63];
    int         nv = 0;
    logic       prev_v = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                chk(!prev_v, "R9 pulse width", 2, 1);
                // coincident write and readback of the same register
                if (rd_chan == res_chan)
                    chk(rd_data == res_data, "R10 same-cycle readback", rd_data, res_data);
                if (nv < 64) begin
                    v_ch[nv]  = res_chan;
                    v_dat[nv] = res_data;
                end
                nv++;
            end
        end
        prev_v = res_valid;
    end

    // ---------------- timing monitor ----------------
    logic prev_cs = 1'b1, prev_adc = 1'b0, prev_sclk = 1'b0, prev_eoc = 1'b1;
    bit   first_fall = 1, sclk_seen = 0, eoc_seen = 0;
    int   wait_rises = 0, setup_rises = 0, eoc_frames = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            first_fall = 1;
            wait_rises = 0;
        end else begin
            if (eoc && !prev_eoc) eoc_seen = 1;
            if (adc_clk && !prev_adc) begin
                if (prev_cs)         wait_rises++;
                else if (!sclk_seen) setup_rises++;
            end
            if (!cs_n && prev_cs) begin
                if (!first_fall) begin
                    if (!wait_mode)
                        chk(wait_rises == 32, "R6 counted wait", wait_rises, 32);
                    else begin
                        chk(eoc_seen, "R7 eoc gate", eoc_seen, 1);
                        eoc_frames++;
                    end
                end
                first_fall  = 0;
                wait_rises  = 0;
                setup_rises = 0;
                sclk_seen   = 0;
            end
            if (cs_n && !prev_cs) eoc_seen = 0;
            if (sclk && !prev_sclk && !sclk_seen) begin
                sclk_seen = 1;
                chk(setup_rises >= 3, "R8 select setup", setup_rises, 3);
            end
        end
        prev_cs   = cs_n;
        prev_adc  = adc_clk;
        prev_sclk = sclk;
        prev_eoc  = eoc;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- vector table ----------------
    localparam logic [3:0] EXP_ADDR [0:11] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
                                               4'd6, 4'd7, 4'd8, 4'd0, 4'd1, 4'd2};

    logic [7:0] exp_bank [0:8];

    initial begin
        int fb, vb;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 9; c++) begin
            rd_chan = 4'(c);
            @(negedge clk);
            chk(rd_data == 8'h00, "R1 bank cleared", rd_data, 0);
        end
        rd_chan = 4'd4;

        // counted mode: twelve frames, walk the table
        while (s_frames < 12) @(negedge clk);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            chk(s_hist[i] == EXP_ADDR[i], "R2 address order", s_hist[i], EXP_ADDR[i]);
            chk(s_pad[i] == 4'h0, "R2 trailing zeros", s_pad[i], 0);
            if (i > 0) begin
                chk(v_ch[i-1] == EXP_ADDR[i-1], "R5 result channel", v_ch[i-1], EXP_ADDR[i-1]);
                chk(v_dat[i-1] == s_val[i-1], "R4 result byte", v_dat[i-1], s_val[i-1]);
            end
        end
        chk(nv == 11, "R5 first byte discarded", nv, 11);

        // R10: readback of every register, plus out-of-range selects
        for (int c = 0; c < 9; c++) exp_bank[c] = 8'h00;
        for (int j = 0; j < 11; j++) exp_bank[EXP_ADDR[j]] = s_val[j];
        for (int c = 0; c < 9; c++) begin
            rd_chan = 4'(c);
            @(negedge clk);
            chk(rd_data == exp_bank[c], "R10 readback", rd_data, exp_bank[c]);
        end
        rd_chan = 4'd9;
        @(negedge clk);
        chk(rd_data == 8'h00, "R10 index 9 reads zero", rd_data, 0);
        rd_chan = 4'd15;
        @(negedge clk);
        chk(rd_data == 8'h00, "R10 index 15 reads zero", rd_data, 0);

        // handshake mode after a fresh reset
        rst_n = 1'b0;
        wait_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in second reset", cs_n, 1);
        rd_chan = 4'd0;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1 bank cleared again", rd_data, 0);
        fb = s_frames;
        vb = nv;
        rst_n = 1'b1;
        while (s_frames < fb + 4) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(s_hist[fb] == 4'd0, "R2 restart at channel 0", s_hist[fb], 0);
        chk(s_hist[fb+1] == 4'd1, "R2 second address", s_hist[fb+1], 1);
        chk(nv == vb + 3, "R5 discard after reset", nv - vb, 3);
        chk(v_ch[vb] == 4'd0, "R5 channel in handshake mode", v_ch[vb], 0);
        chk(v_dat[vb] == s_val[fb], "R4 byte in handshake mode", v_dat[vb], s_val[fb]);
        chk(eoc_frames >= 3, "R7 handshake frames started", eoc_frames, 3);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule